// File: doc/BRIEF.md
# Packet Memory Pointer and Data Window

This block gives a host byte-wide access to a packet RAM that is split into 2 KB pages. The host first loads a 16-bit pointer register, one byte per write, and then moves packet bytes through a data window of four byte lanes. The low eleven pointer bits give a byte offset inside the page. Bit 15 selects which page is addressed: either the page at the head of the receive queue or the page held in the packet-number register. Both page numbers come from outside the block. When bit 14 is set, every access to the data window moves the pointer to the next byte. This lets the host stream a whole frame without reloading the pointer.

Each data-window access transfers exactly one byte. The lane offset (0 to 3) is added to the pointer offset, and the sum wraps inside the page. The pointer advances by one per access, whichever lane is used. Bits 15 to 11 of the pointer never change on an advance. A read of the pointer's high byte hides bit 11. Read data is registered and appears on the bus in the cycle after the read strobe. The packet RAM is held inside the block as a plain array.

Top module: `pkt_mem_window`

## Requirements
- R1: After reset the pointer is 0x0000 and `bus_rdata` is 0x00.
- R2: A write to offset 6 loads pointer bits [7:0] only, and a write to offset 7 loads bits [15:8] only.
- R3: A read of offset 6 returns pointer bits [7:0]. A read of offset 7 returns bits [15:8] ANDed with 0xF7, so bit 11 reads as 0.
- R4: A write to offsets 8 to 11 (address bits [3:2] = 2'b10) stores the byte at page location (pointer[10:0] + address[1:0]) mod 2048.
- R5: A read strobe places its result on `bus_rdata` in the next cycle. The value then holds until the next read that is taken.
- R6: With pointer bit 14 set, each data-window access, read or write and on any lane, adds one to the pointer offset. With bit 14 clear, the pointer does not change.
- R7: An advance wraps the offset from 2047 to 0 and leaves pointer bits [15:11] unchanged.
- R8: Pointer bit 15 = 1 addresses the page given by `rxq_head_page`. Bit 15 = 0 addresses the page given by `pkt_page`.
- R9: Writes to offsets other than 6 to 11 are ignored, and reads of them return 0x00. An access outside the data window never advances the pointer.
- R10: When `bus_wr` and `bus_rd` are both high, only the write is performed. `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 4 | Byte offset in the register bank |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pkt_page | input | PAGE_W | Page number from the packet-number register |
| rxq_head_page | input | PAGE_W | Page number at the head of the receive queue |

## Verification
Bytes are written through every lane, both with auto-increment on and with it off. This separates an offset that depends on the lane from an advance that does not depend on the lane. The same offset is then written in both pages, and read back under each setting of bit 15 and each value of the two page inputs. This shows whether the page is chosen by the right source. Pointers near the top of a page test the lane-sum wrap and the advance wrap. Pointer values with bits 15 and 11 set show whether control bits survive an advance and whether bit 11 is masked on readback. Further cases cover unmapped offsets, read and write strobes high in the same cycle, and partial pointer writes.

// File: rtl/pktwin_pkg.sv
package pktwin_pkg;
  localparam int OFS_W  = 11;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 2;

  localparam int BIT_AUTOINC = 14;
  localparam int BIT_RXSEL   = 15;
  localparam int BIT_HIDDEN  = 11;

  localparam logic [3:0] ADDR_PTR_LO = 4'd6;
  localparam logic [3:0] ADDR_PTR_HI = 4'd7;
  localparam logic [1:0] WIN_SEG     = 2'b10;

  localparam logic [BYTE_W-1:0] HI_READ_MASK =
    ~(BYTE_W'(1) << (BIT_HIDDEN - BYTE_W));

  typedef struct packed {
    logic ptr_lo_wr;
    logic ptr_hi_wr;
    logic win_wr;
    logic win_rd;
    logic reg_rd;
  } acc_t;

  function automatic acc_t decode_acc(input logic wr, input logic rd,
                                      input logic [3:0] addr);
    acc_t a;
    logic in_win;
    in_win      = (addr[3:2] == WIN_SEG);
    a.ptr_lo_wr = wr && (addr == ADDR_PTR_LO);
    a.ptr_hi_wr = wr && (addr == ADDR_PTR_HI);
    a.win_wr    = wr && in_win;
    a.win_rd    = rd && !wr && in_win;
    a.reg_rd    = rd && !wr && !in_win;
    return a;
  endfunction
endpackage

// File: rtl/pktwin_rst_sync.sv
module pktwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pktwin_ptr_reg.sv
module pktwin_ptr_reg
  import pktwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              advance,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr_q
);
  localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = lo_we || hi_we || advance;
    if (lo_we) begin
      ptr_d[BYTE_W-1:0] = wdata;
    end
    if (hi_we) begin
      ptr_d[PTR_W-1:BYTE_W] = wdata;
    end
    if (advance) begin
      ptr_d[OFS_W-1:0] = ptr_q[OFS_W-1:0] + OFS_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/pktwin_addr_gen.sv
module pktwin_addr_gen
  import pktwin_pkg::*;
#(
  parameter int PAGE_W = 1
) (
  input  logic              rx_sel,
  input  logic [OFS_W-1:0]  offset,
  input  logic [LANE_W-1:0] lane,
  input  logic [PAGE_W-1:0] pkt_page,
  input  logic [PAGE_W-1:0] rxq_page,
  output logic [PAGE_W+OFS_W-1:0] ram_addr
);
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  byte_ofs;

  always_comb begin
    page     = rx_sel ? rxq_page : pkt_page;
    byte_ofs = offset + OFS_W'(lane);
    ram_addr = {page, byte_ofs};
  end
endmodule

// File: rtl/pktwin_ram.sv
module pktwin_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/pkt_mem_window.sv
module pkt_mem_window
  import pktwin_pkg::*;
#(
  parameter int PAGE_COUNT = 2,
  localparam int PAGE_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PAGE_W-1:0] pkt_page,
  input  logic [PAGE_W-1:0] rxq_head_page
);
  localparam int RAM_AW = PAGE_W + OFS_W;

  logic              rst_n_s;
  acc_t              acc;
  logic [PTR_W-1:0]  ptr_q;
  logic              advance;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]        ram_q;
  logic [7:0]        reg_rb;
  logic [7:0]        reg_q;
  logic [7:0]        reg_d;
  logic              sel_ram_q;
  logic              sel_ram_d;
  logic              rd_en;

  pktwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    acc     = decode_acc(bus_wr, bus_rd, bus_addr);
    advance = (acc.win_wr || acc.win_rd) && ptr_q[BIT_AUTOINC];
  end

  pktwin_ptr_reg u_ptr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .lo_we   (acc.ptr_lo_wr),
    .hi_we   (acc.ptr_hi_wr),
    .advance (advance),
    .wdata   (bus_wdata),
    .ptr_q   (ptr_q)
  );

  pktwin_addr_gen #(.PAGE_W(PAGE_W)) u_agen (
    .rx_sel   (ptr_q[BIT_RXSEL]),
    .offset   (ptr_q[OFS_W-1:0]),
    .lane     (bus_addr[LANE_W-1:0]),
    .pkt_page (pkt_page),
    .rxq_page (rxq_head_page),
    .ram_addr (ram_addr)
  );

  pktwin_ram #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk   (clk),
    .we    (acc.win_wr),
    .re    (acc.win_rd),
    .addr  (ram_addr),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_PTR_LO: reg_rb = ptr_q[7:0];
      ADDR_PTR_HI: reg_rb = ptr_q[15:8] & HI_READ_MASK;
      default:     reg_rb = 8'h00;
    endcase
    rd_en     = acc.win_rd || acc.reg_rd;
    sel_ram_d = acc.win_rd;
    reg_d     = acc.reg_rd ? reg_rb : reg_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      reg_q     <= 8'h00;
      sel_ram_q <= 1'b0;
    end else if (rd_en) begin
      reg_q     <= reg_d;
      sel_ram_q <= sel_ram_d;
    end
  end

  assign bus_rdata = sel_ram_q ? ram_q : reg_q;
endmodule

// File: rtl/pktwin_chk.sv
module pktwin_chk
  import pktwin_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic             rd,
  input logic [3:0]       addr,
  input logic [PTR_W-1:0] ptr,
  input logic [7:0]       rdata
);
  logic in_win;
  logic ptr_wr;
  assign in_win = (addr[3:2] == WIN_SEG);
  assign ptr_wr = wr && (addr == ADDR_PTR_LO || addr == ADDR_PTR_HI);

  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) && in_win && ptr[BIT_AUTOINC]
    |=> ptr[OFS_W-1:0] == $past(ptr[OFS_W-1:0]) + 11'd1);

  a_r6_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) && in_win && !ptr[BIT_AUTOINC] |=> $stable(ptr));

  a_r7_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) && in_win |=> ptr[15:11] == $past(ptr[15:11]));

  a_r9_outside_still: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) && !in_win && !ptr_wr |=> $stable(ptr));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr && rd |=> $stable(rdata));

  a_r3_hidden_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !wr && addr == ADDR_PTR_HI |=> rdata[3] == 1'b0);
endmodule

bind pkt_mem_window pktwin_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .wr    (bus_wr),
  .rd    (bus_rd),
  .addr  (bus_addr),
  .ptr   (ptr_q),
  .rdata (bus_rdata)
);

// File: tb/pkt_mem_window_tb.sv
module pkt_mem_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 22;

  // {is_read, addr, wdata, expected}
  localparam logic [20:0] VEC [N_VEC] = '{
    {1'b0, 4'h6, 8'h10, 8'h00},  // ptr lo
    {1'b0, 4'h7, 8'h40, 8'h00},  // R6 auto-increment on, page from pkt_page
    {1'b0, 4'h8, 8'hA1, 8'h00},  // R4 lane0 -> 0x010
    {1'b0, 4'h9, 8'hB2, 8'h00},  // R4 lane1 -> 0x012
    {1'b0, 4'hB, 8'hC3, 8'h00},  // R4 lane3 -> 0x015
    {1'b1, 4'h6, 8'h00, 8'h13},  // R6 three advances
    {1'b1, 4'h7, 8'h00, 8'h40},
    {1'b0, 4'h6, 8'h10, 8'h00},
    {1'b0, 4'h7, 8'h00, 8'h00},  // auto-increment off
    {1'b1, 4'h8, 8'h00, 8'hA1},  // R5
    {1'b1, 4'hA, 8'h00, 8'hB2},
    {1'b1, 4'h6, 8'h00, 8'h10},  // R6 no advance
    {1'b0, 4'h6, 8'h12, 8'h00},
    {1'b1, 4'hB, 8'h00, 8'hC3},
    {1'b0, 4'h7, 8'h88, 8'h00},  // R8 rx page, bit 11 set
    {1'b1, 4'h7, 8'h00, 8'h80},  // R3 bit 11 hidden
    {1'b0, 4'h8, 8'h5E, 8'h00},  // page 1, 0x012
    {1'b0, 4'h7, 8'h00, 8'h00},
    {1'b1, 4'h8, 8'h00, 8'hB2},  // page 0 intact
    {1'b0, 4'h7, 8'h80, 8'h00},
    {1'b1, 4'h8, 8'h00, 8'h5E},
    {1'b1, 4'h6, 8'h00, 8'h12}
  };

  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic       bus_rd;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [0:0] pkt_page;
  logic [0:0] rxq_head_page;

  int checks = 0;
  int fails  = 0;

  pkt_mem_window dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .pkt_page      (pkt_page),
    .rxq_head_page (rxq_head_page)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    do_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;
    pkt_page = 1'b0; rxq_head_page = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    rd_chk("R1 ptr lo after reset", 4'h6, 8'h00);
    rd_chk("R1 ptr hi after reset", 4'h7, 8'h00);

    // Vector table
    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][20]) begin
        rd_chk($sformatf("R4/R5/R6/R8 table row %0d", i), VEC[i][19:16], VEC[i][7:0]);
      end else begin
        do_wr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    // R5 data holds without further reads
    repeat (3) @(negedge clk);
    chk("R5 rdata held", bus_rdata, 8'h12);

    // R2 independent byte writes
    do_wr(4'h7, 8'h12);
    rd_chk("R2 hi after hi write", 4'h7, 8'h12);
    do_wr(4'h6, 8'h34);
    rd_chk("R2 hi kept on lo write", 4'h7, 8'h12);
    rd_chk("R2 lo written", 4'h6, 8'h34);
    do_wr(4'h7, 8'h56);
    rd_chk("R2 lo kept on hi write", 4'h6, 8'h34);

    // R4 lane sum wraps inside the page
    do_wr(4'h6, 8'hFE);
    do_wr(4'h7, 8'h07);
    do_wr(4'hB, 8'h77);
    do_wr(4'h6, 8'h01);
    do_wr(4'h7, 8'h00);
    rd_chk("R4 lane wrap to 0x001", 4'h8, 8'h77);

    // R7 advance wrap with control bits kept
    do_wr(4'h6, 8'hFF);
    do_wr(4'h7, 8'hC7);
    do_wr(4'h8, 8'h99);
    rd_chk("R7 offset wrapped lo", 4'h6, 8'h00);
    rd_chk("R7 control bits kept", 4'h7, 8'hC0);
    do_wr(4'h6, 8'hFF);
    do_wr(4'h7, 8'h87);
    rd_chk("R7 byte at 0x7FF", 4'h8, 8'h99);

    // R8 page source selection
    do_wr(4'h6, 8'h12);
    do_wr(4'h7, 8'h80);
    @(negedge clk); rxq_head_page = 1'b0;
    rd_chk("R8 rx head page 0", 4'h8, 8'hB2);
    @(negedge clk); rxq_head_page = 1'b1;
    rd_chk("R8 rx head page 1", 4'h8, 8'h5E);
    do_wr(4'h7, 8'h00);
    @(negedge clk); pkt_page = 1'b1;
    rd_chk("R8 pkt page 1", 4'h8, 8'h5E);
    @(negedge clk); pkt_page = 1'b0;
    rd_chk("R8 pkt page 0", 4'h8, 8'hB2);

    // R9 unmapped offsets and pointer reads
    do_wr(4'h3, 8'hFF);
    rd_chk("R9 lo after unmapped write", 4'h6, 8'h12);
    rd_chk("R9 hi after unmapped write", 4'h7, 8'h00);
    rd_chk("R9 unmapped read", 4'h3, 8'h00);
    do_wr(4'h7, 8'h40);
    rd_chk("R9 ptr read no advance a", 4'h6, 8'h12);
    rd_chk("R9 ptr read no advance b", 4'h6, 8'h12);

    // R10 read and write in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'h8; bus_wdata = 8'hE4;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 rdata held", bus_rdata, 8'h12);
    rd_chk("R10 write advanced ptr", 4'h6, 8'h13);
    do_wr(4'h6, 8'h12);
    do_wr(4'h7, 8'h00);
    rd_chk("R10 write stored", 4'h8, 8'hE4);

    finish_run();
  end
endmodule